// File: doc/BRIEF.md
# Interrupt Aggregator with DMA Halt Control

This block gathers interrupt requests from ordinary peripherals and from DMA channels into one level-sensitive request line for a CPU. A status word and an enable word sit on a small 32-bit register bus. The CPU request is high whenever any enabled status bit is set.

Lines below a parameterised boundary index are plain device requests. Their status bits mirror the device inputs, and software quiets them only by disabling them. Lines at or above the boundary are DMA events. Each event latches on its input and stays set until software writes a zero to its bit.

DMA events come in two classes, chosen by a constant bit pattern. Informational events never stop their channel and may set again as soon as they are cleared. Error events raise a per-channel halt that holds the channel until software clears the event. The halt does not depend on the enable word. The register bus is a plain single-cycle interface with no handshake. There is no data stream at the block's edge, so every pin is a plain control or status signal.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable word is 0, every DMA event bit is 0, `cpu_irq` is 0, every `dma_halt` bit is 0, and reads at offsets 0 and 4 return 0 when no device input is high.
- R2: A write at offset 4 loads the enable word. A bit set to 1 enables its line. A read returns the addressed word in `bus_rdata` one cycle after the address is presented: offset 0 returns status, offset 4 returns the enable word, and any other offset returns 0.
- R3: Status bits 0 to 15 (below the boundary, by default) always equal the matching `dev_irq` inputs. Writes to offset 0 never change them.
- R4: Status bit 16+j is set at the first clock edge where `dma_evt[j]` is high. It then stays set after the input falls.
- R5: A write at offset 0 clears each DMA event bit whose write-data bit is 0. It leaves each bit whose write-data bit is 1 unchanged.
- R6: If `dma_evt[j]` is high in the same cycle as a write that clears bit 16+j, the bit stays 1.
- R7: For an error-class channel j, `dma_halt[j]` is high while status bit 16+j is set. It falls in the cycle after the clearing write. It stays high even when the line is disabled in the enable word.
- R8: Informational channels never assert `dma_halt`. By default these are status bits 19, 20, 21, 22 and 24, that is channels 3, 4, 5, 6 and 8. Such a channel can set again right after being cleared.
- R9: `cpu_irq` is high exactly while the bitwise AND of status and the enable word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 16 | Level requests from devices (status bits 0..15) |
| dma_evt | input | 16 | DMA event strobes (status bits 16..31) |
| bus_addr | input | 4 | Register byte offset: 0 status, 4 enable |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Combined level interrupt to the CPU |
| dma_halt | output | 16 | Per-channel stall for error-class events |

## Verification
The assertions assume that `dma_evt` and the bus inputs are synchronous to `clk` and stable around each rising edge. They also assume that a status clear is signalled only by a write at offset 0. The bench changes every input on the falling edge and holds it through the next rising edge. It never issues a read and a write in the same cycle unless the write is the stimulus under test. It raises events on both classes, including one cycle where an event and its own clear coincide.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h4;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    if (a == OFS_STATUS)      return SEL_STATUS;
    else if (a == OFS_ENABLE) return SEL_ENABLE;
    else                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_regbus.sv
module irq_regbus
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] enable,
  output logic              status_wr,
  output logic              enable_wr,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    sel       = decode_ofs(addr);
    status_wr = we && (sel == SEL_STATUS);
    enable_wr = we && (sel == SEL_ENABLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      unique case (sel)
        SEL_STATUS: rdata <= status;
        SEL_ENABLE: rdata <= enable;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int                NUM_EVT  = 16,
  parameter logic [NUM_EVT-1:0] INFO_SEL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_keep,
  output logic [NUM_EVT-1:0] evt_q,
  output logic [NUM_EVT-1:0] halt
);
  for (genvar j = 0; j < NUM_EVT; j++) begin : g_chan
    logic clr_hit;
    assign clr_hit = clr_wr && !clr_keep[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          evt_q[j] <= 1'b0;
      else if (evt_in[j])  evt_q[j] <= 1'b1;
      else if (clr_hit)    evt_q[j] <= 1'b0;
    end

    if (INFO_SEL[j]) begin : g_info
      assign halt[j] = 1'b0;
    end else begin : g_err
      assign halt[j] = evt_q[j];
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0] status,
  input  logic [LINES-1:0] enable,
  output logic             irq
);
  assign irq = |(status & enable);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int              NUM_LINES = 32,
  parameter int              DMA_BASE  = 16,
  parameter logic [31:0]     INFO_MASK = 32'h0178_0000,
  localparam int             NUM_DMA   = NUM_LINES - DMA_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DMA_BASE-1:0]  dev_irq,
  input  logic [NUM_DMA-1:0]   dma_evt,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 cpu_irq,
  output logic [NUM_DMA-1:0]   dma_halt
);
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] enable_q;
  logic [NUM_DMA-1:0]   evt_q;
  logic                 status_wr;
  logic                 enable_wr;

  irq_regbus #(.DATA_W(NUM_LINES)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .we        (bus_we),
    .status    (status),
    .enable    (enable_q),
    .status_wr (status_wr),
    .enable_wr (enable_wr),
    .rdata     (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable_q <= '0;
    else if (enable_wr) enable_q <= bus_wdata;
  end

  irq_event_bank #(
    .NUM_EVT  (NUM_DMA),
    .INFO_SEL (INFO_MASK[NUM_LINES-1:DMA_BASE])
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (dma_evt),
    .clr_wr   (status_wr),
    .clr_keep (bus_wdata[NUM_LINES-1:DMA_BASE]),
    .evt_q    (evt_q),
    .halt     (dma_halt)
  );

  assign status = {evt_q, dev_irq};

  irq_combine #(.LINES(NUM_LINES)) u_comb (
    .status (status),
    .enable (enable_q),
    .irq    (cpu_irq)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int          NUM_LINES = 32,
  parameter int          DMA_BASE  = 16,
  parameter logic [31:0] INFO_MASK = 32'h0178_0000
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_evt,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_we,
  input logic [NUM_LINES-1:0]          bus_wdata,
  input logic                          cpu_irq,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_halt,
  input logic [NUM_LINES-1:0]          status,
  input logic [NUM_LINES-1:0]          enable_q
);
  localparam int NDMA = NUM_LINES - DMA_BASE;

  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_ENABLE) |=> (enable_q == $past(bus_wdata)));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (enable_q != '0));

  for (genvar j = 0; j < NDMA; j++) begin : g_c
    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      dma_evt[j] |=> status[DMA_BASE+j]);

    a_r5_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (status[DMA_BASE+j] &&
       !(bus_we && bus_addr == OFS_STATUS && !bus_wdata[DMA_BASE+j]))
      |=> status[DMA_BASE+j]);

    if (INFO_MASK[DMA_BASE+j]) begin : g_i
      a_r8_info_never_halts: assert property (@(posedge clk) disable iff (!rst_n)
        status[DMA_BASE+j] |-> !dma_halt[j]);
    end else begin : g_e
      a_r7_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt[j] &&
         !(bus_we && bus_addr == OFS_STATUS && !bus_wdata[DMA_BASE+j]))
        |=> dma_halt[j]);
    end
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES (NUM_LINES),
  .DMA_BASE  (DMA_BASE),
  .INFO_MASK (INFO_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dma_evt   (dma_evt),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .cpu_irq   (cpu_irq),
  .dma_halt  (dma_halt),
  .status    (status),
  .enable_q  (enable_q)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_irq = '0;
  logic [15:0] dma_evt = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic [15:0] dma_halt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .dma_evt(dma_evt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .dma_halt(dma_halt)
  );

  typedef struct packed {
    logic [15:0] dev;
    logic [15:0] evt;
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        irq;
    logic [15:0] halt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b1, 4'h4, 32'h0001_0009, 1'b0, 16'h0000}, // R2 enable 0,3,16
    '{16'h0008, 16'h0000, 1'b0, 4'h0, 32'h0,         1'b1, 16'h0000}, // R9 enabled dev line
    '{16'h0004, 16'h0000, 1'b0, 4'h0, 32'h0,         1'b0, 16'h0000}, // R9 disabled dev line
    '{16'h0000, 16'h0001, 1'b0, 4'h0, 32'h0,         1'b1, 16'h0001}, // R4/R7 error event
    '{16'h0000, 16'h0000, 1'b0, 4'h0, 32'h0,         1'b1, 16'h0001}, // R4 held
    '{16'h0000, 16'h0000, 1'b1, 4'h4, 32'h0000_0009, 1'b0, 16'h0001}, // R7 halt ignores enable
    '{16'h0000, 16'h0008, 1'b0, 4'h0, 32'h0,         1'b0, 16'h0001}, // R8 info event no halt
    '{16'h0000, 16'h0000, 1'b1, 4'h0, 32'hFFFE_FFFF, 1'b0, 16'h0000}, // R5/R7 clear line 16
    '{16'h0000, 16'h0000, 1'b1, 4'h4, 32'h0008_0000, 1'b1, 16'h0000}, // R5 line 19 kept
    '{16'h0000, 16'h0008, 1'b1, 4'h0, 32'hFFF7_FFFF, 1'b1, 16'h0000}, // R6 set wins
    '{16'h0000, 16'h0000, 1'b1, 4'h0, 32'hFFF7_FFFF, 1'b0, 16'h0000}, // R5 clear line 19
    '{16'h0008, 16'h0200, 1'b0, 4'h0, 32'h0,         1'b0, 16'h0200}  // R7 line 25, R9 disabled
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] d, input logic [15:0] e, input logic w,
                       input logic [3:0] a, input logic [31:0] wd);
    @(negedge clk);
    dev_irq = d; dma_evt = e; bus_we = w; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] d, input logic [3:0] a, input string req,
                    input logic [31:0] exp);
    drive(d, 16'h0, 1'b0, a, 32'h0);
    chk(req, bus_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq", {31'h0, cpu_irq}, 32'h0);
    chk("R1 halt", {16'h0, dma_halt}, 32'h0);
    rst_n = 1'b1;
    rd(16'h0, 4'h0, "R1 status", 32'h0);
    rd(16'h0, 4'h4, "R1 enable", 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].dev, VECS[i].evt, VECS[i].we, VECS[i].addr, VECS[i].wdata);
      chk($sformatf("R9 irq vec%0d", i), {31'h0, cpu_irq}, {31'h0, VECS[i].irq});
      chk($sformatf("R7 halt vec%0d", i), {16'h0, dma_halt}, {16'h0, VECS[i].halt});
    end

    rd(16'h0, 4'h4, "R2 enable readback", 32'h0008_0000);
    rd(16'h0005, 4'h0, "R3 status mirrors dev", 32'h0200_0005);
    rd(16'h0, 4'h8, "R2 unmapped offset", 32'h0);

    // R3: clearing write of all zeros leaves device bits, clears events
    drive(16'h0005, 16'h0, 1'b1, 4'h0, 32'h0);
    chk("R7 halt released", {16'h0, dma_halt}, 32'h0);
    rd(16'h0005, 4'h0, "R3 device bits kept", 32'h0000_0005);

    // R8: info channel 8 (bit 24) sets, no halt, clears, sets again
    drive(16'h0, 16'h0100, 1'b0, 4'h0, 32'h0);
    chk("R8 no halt", {16'h0, dma_halt}, 32'h0);
    drive(16'h0, 16'h0, 1'b1, 4'h0, 32'hFEFF_FFFF);
    rd(16'h0, 4'h0, "R5 info cleared", 32'h0);
    drive(16'h0, 16'h0100, 1'b0, 4'h0, 32'h0);
    rd(16'h0, 4'h0, "R8 info re-set", 32'h0100_0000);

    // R9: enable bit 24 raises irq
    drive(16'h0, 16'h0, 1'b1, 4'h4, 32'h0100_0000);
    chk("R9 irq on enabled event", {31'h0, cpu_irq}, 32'h1);

    // R1: reset again returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'h0, cpu_irq}, 32'h0);
    rd(16'h0, 4'h0, "R1 status after reset", 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule